// File: doc/BRIEF.md
# Core-Paced Link Word Buffer

This block sits between one link port's word-level side and a processor core. It holds a two-entry receive queue that the link side fills and a two-entry transmit queue that the link side drains. With both queues, up to four words can be in flight before the core has to read anything. The core reaches both queues, and a small control/status word, through a register-style interface. `core_req` marks an access. `core_we` selects a write. `core_addr` selects the target.

The core's pace follows the queues. A read from an empty receive queue, or a write to a full transmit queue, holds `core_stall` high until the link side completes a word. A hang-disable control bit removes the stall. With that bit set, a read from an empty queue returns the last word read, and a write to a full queue is dropped and raises a sticky error flag. Direct core access only takes effect while the port's DMA-enable control bit is clear.

Address map:
- 0: receive data (read)
- 1: transmit data (write)
- 2: control on write, status on read
- 3: unused; reads return zero

Top module: `link_buf_core`

## Requirements
- R1: Each queue holds DEPTH (2) words. With no core reads, two link words are accepted and `lrx_ready` then drops. With the link not accepting, two core writes complete without stall and a third stalls.
- R2: With hang-disable clear, a core read at address 0 while the receive queue is empty holds `core_stall` high. In the first cycle `lrx_valid` is high, the stall drops and `core_rdata` equals `lrx_data`. That word is not stored.
- R3: With hang-disable clear, a core write at address 1 while the transmit queue is full holds `core_stall` high. In the cycle that `ltx_valid && ltx_ready` frees a slot, the stall drops and the write is stored.
- R4: While hang-disable is set, `core_stall` is never asserted.
- R5: With hang-disable set, a read of the empty receive queue returns the last word read from it, or zero after reset, and removes nothing.
- R6: With hang-disable set, a write to the full transmit queue is dropped and sets a sticky error flag. A status read returns the flag and clears it.
- R7: A write to address 2 loads control: bit 0 is hang-disable and bit 1 is DMA-enable. A read of address 2 returns status: bit 0 hang-disable, bit 1 DMA-enable, bit 2 receive empty, bit 3 receive full, bit 4 transmit empty, bit 5 transmit full, bit 6 error. All other bits read zero.
- R8: While DMA-enable is set, core accesses to addresses 0 and 1 do not stall, return zero and change neither queue.
- R9: When the receive queue is full and a core read pops it, `lrx_ready` stays high. A link word pushed in that cycle is accepted, and the queue stays full.
- R10: After reset both queues are empty, `lrx_ready` is 1, `ltx_valid` is 0, and hang-disable, DMA-enable and error read 0.
- R11: Each queue delivers words in the order they entered. `ltx_data` shows the oldest transmit word while `ltx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core access request |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 2 | 0 receive data, 1 transmit data, 2 control/status |
| core_wdata | input | DATA_W | Core write data |
| core_rdata | output | DATA_W | Core read data, valid in a non-stalled read cycle |
| core_stall | output | 1 | Holds the core access until it can complete |
| lrx_valid | input | 1 | Link side offers a received word |
| lrx_data | input | DATA_W | Received word |
| lrx_ready | output | 1 | Receive side can take a word this cycle |
| ltx_valid | output | 1 | A transmit word is available |
| ltx_data | output | DATA_W | Oldest transmit word |
| ltx_ready | input | 1 | Link side takes the transmit word this cycle |

## Verification
Two functions can fall in the same cycle on each queue, and the bench provokes both. On the receive side, a core pop can meet a link push, either on a full queue or as a pass-through on an empty queue that releases a stall. On the transmit side, a link drain can meet a core write to a full queue. Directed sequences fill a queue, then present both events together. A long random phase makes such collisions frequent. A behavioural queue model predicts stall, read data, ready and valid for every cycle, and the bench compares them each clock.

// File: rtl/link_buf_pkg.sv
package link_buf_pkg;
   typedef enum logic [1:0] {
      A_RXD  = 2'd0,
      A_TXD  = 2'd1,
      A_CSR  = 2'd2,
      A_NONE = 2'd3
   } lb_addr_t;

   localparam int ST_HD     = 0;
   localparam int ST_DE     = 1;
   localparam int ST_RXE    = 2;
   localparam int ST_RXF    = 3;
   localparam int ST_TXE    = 4;
   localparam int ST_TXF    = 5;
   localparam int ST_ERR    = 6;
   localparam int ST_BITS   = 7;
endpackage

// File: rtl/lb_fifo.sv
module lb_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] count;

   if (DEPTH < 1) begin : g_bad_depth
      $error("lb_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] slot;
      logic         occ;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            occ  <= 1'b0;
            slot <= '0;
         end else begin
            if (push) slot <= wdata;
            if (push) occ <= 1'b1;
            else if (pop) occ <= 1'b0;
         end
      end
      assign head  = slot;
      assign count = CW'(occ);
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      logic [W-1:0]  mem [DEPTH];
      logic [PW-1:0] rp, wp;
      logic [CW-1:0] cnt;

      function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
         return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
      endfunction

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
         end else begin
            if (push) begin
               mem[wp] <= wdata;
               wp      <= bump(wp);
            end
            if (pop) rp <= bump(rp);
            if (push && !pop) cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
         end
      end
      assign head  = mem[rp];
      assign count = cnt;
   end

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> !full);
   // R11
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R9
   swap_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> (count == $past(count)));
endmodule

// File: rtl/lb_csr.sv
module lb_csr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctrl_we,
   input  logic         hd_d,
   input  logic         de_d,
   input  logic         err_set,
   input  logic         err_clr,
   input  logic         last_ld,
   input  logic [W-1:0] last_d,
   output logic         hd,
   output logic         de,
   output logic         err,
   output logic [W-1:0] last
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hd   <= 1'b0;
         de   <= 1'b0;
         err  <= 1'b0;
         last <= '0;
      end else begin
         if (ctrl_we) begin
            hd <= hd_d;
            de <= de_d;
         end
         if (err_set) err <= 1'b1;
         else if (err_clr) err <= 1'b0;
         if (last_ld) last <= last_d;
      end
   end

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !err_clr) |=> err);
   // R6
   err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !err_set) |=> !err);
endmodule

// File: rtl/link_buf_core.sv
module link_buf_core
   import link_buf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_req,
   input  logic              core_we,
   input  logic [1:0]        core_addr,
   input  logic [DATA_W-1:0] core_wdata,
   output logic [DATA_W-1:0] core_rdata,
   output logic              core_stall,
   input  logic              lrx_valid,
   input  logic [DATA_W-1:0] lrx_data,
   output logic              lrx_ready,
   output logic              ltx_valid,
   output logic [DATA_W-1:0] ltx_data,
   input  logic              ltx_ready
);
   if (DATA_W < ST_BITS) begin : g_bad_width
      $error("link_buf_core: DATA_W too narrow for status word");
   end

   lb_addr_t     sel;
   logic         rd_rx, wr_tx, csr_rd, csr_wr;
   logic         rx_hit, tx_hit;
   logic         rx_push, rx_pop, rx_bypass, rx_empty, rx_full;
   logic         tx_push, tx_pop, tx_room, tx_drop, tx_empty, tx_full;
   logic         hd, de, err;
   logic [DATA_W-1:0] rx_head, tx_head, last, status;

   assign sel    = lb_addr_t'(core_addr);
   assign rd_rx  = core_req && !core_we && (sel == A_RXD);
   assign wr_tx  = core_req &&  core_we && (sel == A_TXD);
   assign csr_rd = core_req && !core_we && (sel == A_CSR);
   assign csr_wr = core_req &&  core_we && (sel == A_CSR);

   assign rx_hit = rd_rx && !de;
   assign tx_hit = wr_tx && !de;

   // receive path
   assign rx_pop    = rx_hit && !rx_empty;
   assign rx_bypass = rx_hit && rx_empty && lrx_valid;
   assign lrx_ready = !rx_full || rx_pop;
   assign rx_push   = lrx_valid && lrx_ready && !rx_bypass;

   // transmit path
   assign ltx_valid = !tx_empty;
   assign ltx_data  = tx_head;
   assign tx_pop    = !tx_empty && ltx_ready;
   assign tx_room   = !tx_full || tx_pop;
   assign tx_push   = tx_hit && tx_room;
   assign tx_drop   = tx_hit && !tx_room && hd;

   assign core_stall = !hd && ((rx_hit && rx_empty && !lrx_valid) ||
                               (tx_hit && !tx_room));

   lb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
      .wdata(lrx_data), .head(rx_head), .empty(rx_empty), .full(rx_full));

   lb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
      .wdata(core_wdata), .head(tx_head), .empty(tx_empty), .full(tx_full));

   lb_csr #(.W(DATA_W)) i_csr (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(csr_wr), .hd_d(core_wdata[0]), .de_d(core_wdata[1]),
      .err_set(tx_drop), .err_clr(csr_rd),
      .last_ld(rx_pop || rx_bypass),
      .last_d(rx_pop ? rx_head : lrx_data),
      .hd(hd), .de(de), .err(err), .last(last));

   always_comb begin
      status          = '0;
      status[ST_HD]   = hd;
      status[ST_DE]   = de;
      status[ST_RXE]  = rx_empty;
      status[ST_RXF]  = rx_full;
      status[ST_TXE]  = tx_empty;
      status[ST_TXF]  = tx_full;
      status[ST_ERR]  = err;
   end

   always_comb begin
      core_rdata = '0;
      if (rx_hit) begin
         if (rx_pop)         core_rdata = rx_head;
         else if (rx_bypass) core_rdata = lrx_data;
         else if (hd)        core_rdata = last;
      end else if (csr_rd) begin
         core_rdata = status;
      end
   end

   // R4
   hang_dis_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hd |-> !core_stall);
   // R8
   dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (de && core_req && (sel == A_RXD || sel == A_TXD))
         |-> (!core_stall && core_rdata == '0));
   // R2
   rx_stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_stall && !core_we) |-> (rx_empty && !lrx_valid));
   // R3
   tx_stall_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_stall && core_we) |=> tx_full);
endmodule

// File: tb/test_link_buf_core.sv
`timescale 1ns/1ps
module test_link_buf_core;
   localparam int W = 32;
   localparam int D = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req = 0, we = 0, rxv = 0, txr = 0;
   logic [1:0]   addr = 0;
   logic [W-1:0] wdata = 0, rxd = 0;
   logic [W-1:0] rdata, txd;
   logic         stall, rxr, txv;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [W-1:0] rxq[$];
   logic [W-1:0] txq[$];
   logic         m_hd = 0, m_de = 0, m_err = 0;
   logic [W-1:0] m_last = 0;

   always #2.5 clk = ~clk;

   link_buf_core #(.DATA_W(W), .DEPTH(D)) i_link_buf_core (
      .clk(clk), .rst_n(rst_n),
      .core_req(req), .core_we(we), .core_addr(addr),
      .core_wdata(wdata), .core_rdata(rdata), .core_stall(stall),
      .lrx_valid(rxv), .lrx_data(rxd), .lrx_ready(rxr),
      .ltx_valid(txv), .ltx_data(txd), .ltx_ready(txr));

   task automatic chk(input string tag, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic drv(input logic r, input logic w, input logic [1:0] a,
                      input logic [W-1:0] wd, input logic v,
                      input logic [W-1:0] d, input logic tr);
      req = r; we = w; addr = a; wdata = wd; rxv = v; rxd = d; txr = tr;
   endtask

   // one clock: predict, compare, advance the model
   task automatic step(input string tag);
      logic rd_rx, wr_tx, csr_rd, csr_wr;
      logic e_stall, e_rxr, e_txv, tpop, rpop, byp, drop, tpush, chk_rd;
      logic [W-1:0] e_rd, st;
      #1;
      rd_rx  = req && !we && addr == 2'd0;
      wr_tx  = req &&  we && addr == 2'd1;
      csr_rd = req && !we && addr == 2'd2;
      csr_wr = req &&  we && addr == 2'd2;
      e_txv = txq.size() > 0;
      tpop  = e_txv && txr;
      e_stall = 0; e_rd = '0; rpop = 0; byp = 0; drop = 0; tpush = 0;
      if (rd_rx && !m_de) begin
         if (rxq.size() > 0) begin e_rd = rxq[0]; rpop = 1; end
         else if (rxv) begin e_rd = rxd; byp = 1; end
         else if (m_hd) e_rd = m_last;
         else e_stall = 1;
      end
      if (wr_tx && !m_de) begin
         if (txq.size() < D || tpop) tpush = 1;
         else if (m_hd) drop = 1;
         else e_stall = 1;
      end
      if (csr_rd) begin
         st = '0;
         st[0] = m_hd; st[1] = m_de;
         st[2] = rxq.size() == 0; st[3] = rxq.size() == D;
         st[4] = txq.size() == 0; st[5] = txq.size() == D;
         st[6] = m_err;
         e_rd = st;
      end
      e_rxr  = (rxq.size() < D) || rpop;
      chk_rd = req && !we && !e_stall;
      chk(tag, "core_stall", W'(stall), W'(e_stall));
      chk(tag, "lrx_ready", W'(rxr), W'(e_rxr));
      chk(tag, "ltx_valid", W'(txv), W'(e_txv));
      if (e_txv) chk(tag, "ltx_data", txd, txq[0]);
      if (chk_rd) chk(tag, "core_rdata", rdata, e_rd);
      @(posedge clk);
      if (rpop) m_last = rxq.pop_front();
      if (byp) m_last = rxd;
      if (rxv && e_rxr && !byp) rxq.push_back(rxd);
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(wdata);
      if (drop) m_err = 1;
      else if (csr_rd) m_err = 0;
      if (csr_wr) begin m_hd = wdata[0]; m_de = wdata[1]; end
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10 reset state
      drv(0,0,0,0,0,0,0); step("R10");
      drv(1,0,2,0,0,0,0); step("R10");
      // R1 fill receive queue, third word refused
      drv(0,0,0,0,1,32'hA1,0); step("R1");
      drv(0,0,0,0,1,32'hA2,0); step("R1");
      drv(0,0,0,0,1,32'hA3,0); step("R1");
      drv(1,0,2,0,0,0,0); step("R7");
      // R9 pop and push together on full queue
      drv(1,0,0,0,1,32'hA3,0); step("R9");
      drv(1,0,2,0,0,0,0); step("R9");
      // R11 order
      drv(1,0,0,0,0,0,0); step("R11");
      drv(1,0,0,0,0,0,0); step("R11");
      // R2 stall on empty, release by link word
      drv(1,0,0,0,0,0,0); step("R2");
      drv(1,0,0,0,0,0,0); step("R2");
      drv(1,0,0,0,1,32'hB7,0); step("R2");
      drv(1,0,2,0,0,0,0); step("R2");
      // R1 / R3 transmit fill and stall
      drv(1,1,1,32'hC1,0,0,0); step("R1");
      drv(1,1,1,32'hC2,0,0,0); step("R1");
      drv(1,1,1,32'hC3,0,0,0); step("R3");
      drv(1,1,1,32'hC3,0,0,0); step("R3");
      drv(1,1,1,32'hC3,0,0,1); step("R3");
      drv(0,0,0,0,0,0,1); step("R11");
      drv(0,0,0,0,0,0,1); step("R11");
      drv(0,0,0,0,0,0,0); step("R3");
      // R4 / R5 hang-disable on empty read
      drv(1,1,2,32'h1,0,0,0); step("R7");
      drv(1,0,0,0,0,0,0); step("R5");
      drv(1,0,0,0,0,0,0); step("R4");
      // R6 dropped write and sticky error
      drv(1,1,1,32'hD1,0,0,0); step("R6");
      drv(1,1,1,32'hD2,0,0,0); step("R6");
      drv(1,1,1,32'hD3,0,0,0); step("R6");
      drv(0,0,0,0,0,0,0); step("R6");
      drv(1,0,2,0,0,0,0); step("R6");
      drv(1,0,2,0,0,0,0); step("R6");
      drv(0,0,0,0,0,0,1); step("R6");
      drv(0,0,0,0,0,0,1); step("R6");
      // R8 DMA enabled: core data accesses ignored
      drv(0,0,0,0,1,32'hE1,0); step("R8");
      drv(1,1,2,32'h2,0,0,0); step("R8");
      drv(1,0,0,0,0,0,0); step("R8");
      drv(1,1,1,32'hEE,0,0,0); step("R8");
      drv(1,0,2,0,0,0,0); step("R8");
      drv(1,1,2,32'h0,0,0,0); step("R8");
      drv(1,0,0,0,0,0,0); step("R8");
      drv(1,0,3,0,0,0,0); step("R7");
      // R11 random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] a;
         logic [W-1:0] wd;
         a  = 2'($urandom % 4);
         wd = $urandom;
         if (a == 2'd2) wd = W'($urandom % 2);
         if (($urandom % 16) == 0 && a == 2'd2) wd = W'($urandom % 4);
         drv(1'($urandom % 2), 1'($urandom % 2), a, wd,
             1'($urandom % 2), $urandom, 1'($urandom % 2));
         step("R11");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule